// File: doc/BRIEF.md
# CRT Vertical Sync and Retrace Interrupt

This block forms the vertical sync pulse of a VGA-style display timing controller and keeps a retrace interrupt flag that software polls. It watches the current scan-line number and a programmed sync start line. It owns one indexed CRT controller register at index 11h. Software reaches that register through an index port and a data port, at 3B4h/3B5h when mono addressing is selected and at 3D4h/3D5h when colour addressing is selected.

The register holds four things. The upper bit locks writes to CRT registers 00h through 07h. One bit is an active-low interrupt enable. One bit is an active-low interrupt clear. A 4-bit field gives the line on which the sync pulse ends, compared against the low four bits of the line number only.

The pending flag never reaches an interrupt pin. It is offered as a status bit that a neighbouring input status register shows in its bit 7. The block also exports the current index and a per-bit write mask, so that the neighbouring CRT registers can honour the lock.

Top module: `crt_vsync_retrace`

## Requirements
- R1: After reset, vsync and the pending flag are 0. The index register reads 00h. Reading the control register gives bit 7 = 0 and bit 5 = 0; its other stored bits are unspecified.
- R2: The control register is selected by writing 11h to the index port and is then accessed through the data port. Ports are 3B4h/3B5h when color_mode is 0 and 3D4h/3D5h when color_mode is 1. Accesses to the other mode's pair have no effect and read 00h. Readback returns the stored bits 7, 5, 4 and 3:0, with bit 6 always 0.
- R3: With bit 7 = 1, crt_wr_mask is 00h for indices 00h–06h and 10h for index 07h. It is FFh for any other index, and FFh for every index when bit 7 = 0. regs_locked mirrors bit 7.
- R4: vsync goes to 1 one clock after line_cnt equals vs_start on all of its bits.
- R5: On a line other than the start line, vsync goes to 0 one clock after the low 4 bits of line_cnt equal the sync end field (bits 3:0). A pulse therefore spans at most 16 lines, and exactly 16 lines when the end field equals the low bits of the start line.
- R6: retrace_irq_pend becomes 1 one clock after vsync rises, provided bit 5 = 0 and bit 4 = 1.
- R7: A vsync rising edge does not set the pending flag while bit 5 = 1 or bit 4 = 0.
- R8: While bit 4 = 0 the pending flag is cleared on the next clock. Otherwise a set flag stays set across later retraces.
- R9: Reading the index port returns the last value written to it. crt_index shows it at all times, and crt_wr_stb pulses for data-port writes to any index other than 11h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| color_mode | input | 1 | 1 selects the 3Dxh port pair, 0 the 3Bxh pair |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while io_rd is high |
| line_cnt | input | LINE_W | Current scan-line number |
| vs_start | input | LINE_W | Line on which vertical sync begins |
| vsync | output | 1 | Vertical sync level, active high |
| retrace_irq_pend | output | 1 | Pending retrace interrupt, for status bit 7 |
| crt_index | output | 8 | Current CRT index value |
| crt_wr_stb | output | 1 | Data-port write aimed at another CRT register |
| crt_wr_mask | output | 8 | Bits of the indexed register that may be written |
| regs_locked | output | 1 | Write lock for registers 00h–07h is on |

## Verification
The sync assertions assume that line_cnt and vs_start stay steady for at least two clocks per line. They also assume the sync end field is not rewritten in the middle of a pulse. The stimulus holds each line for two clocks and programs the control register only while vsync is low. The interrupt properties assume that the enable and clear bits change only through data-port writes. Every stimulus path reaches them that way, including sweeps that wrap the line counter through zero and pulses that span the full 16 lines.

// File: rtl/crt_vs_pkg.sv
// Shared constants and types for the vertical sync / retrace interrupt block.
// Assumes 16-bit I/O addressing and 8-bit CRT registers.
package crt_vs_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int END_W  = 4;

    localparam logic [ADDR_W-1:0] PORT_IDX_MONO  = 16'h03B4;
    localparam logic [ADDR_W-1:0] PORT_DAT_MONO  = 16'h03B5;
    localparam logic [ADDR_W-1:0] PORT_IDX_COLOR = 16'h03D4;
    localparam logic [ADDR_W-1:0] PORT_DAT_COLOR = 16'h03D5;

    localparam logic [DATA_W-1:0] IDX_CTRL   = 8'h11;
    localparam logic [DATA_W-1:0] LOCK_LAST  = 8'h07;
    localparam logic [DATA_W-1:0] EXEMPT_IDX = 8'h07;
    localparam int                EXEMPT_BIT = 4;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_INDEX = 2'd1,
        HIT_DATA  = 2'd2
    } port_hit_e;

    typedef struct packed {
        logic             lock;
        logic             en_n;
        logic             clr_n;
        logic [END_W-1:0] sync_end;
    } ctrl_t;
endpackage

// File: rtl/crt_vs_decode.sv
// Port decoder: maps an I/O address onto the index or data port of the
// currently selected addressing mode. Assumes color_mode is static during
// an access.
module crt_vs_decode
    import crt_vs_pkg::*;
(
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              color_mode,
    output port_hit_e         hit
);
    logic [ADDR_W-1:0] idx_port;
    logic [ADDR_W-1:0] dat_port;

    // Select the active port pair and classify the address.
    always_comb begin
        idx_port = color_mode ? PORT_IDX_COLOR : PORT_IDX_MONO;
        dat_port = color_mode ? PORT_DAT_COLOR : PORT_DAT_MONO;
        if (io_addr == idx_port)
            hit = HIT_INDEX;
        else if (io_addr == dat_port)
            hit = HIT_DATA;
        else
            hit = HIT_NONE;
    end
endmodule

// File: rtl/crt_vs_regs.sv
// Index register, control register at index 11h, readback mux and the
// write-lock mask for CRT registers 00h-07h. Assumes one-cycle strobes.
module crt_vs_regs
    import crt_vs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  port_hit_e         hit,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] idx_q,
    output ctrl_t             ctrl_q,
    output logic              crt_wr_stb,
    output logic [DATA_W-1:0] crt_wr_mask
);
    logic idx_wr;
    logic dat_wr;
    logic ctrl_sel;
    logic in_lock_range;

    assign idx_wr        = io_wr && (hit == HIT_INDEX);
    assign dat_wr        = io_wr && (hit == HIT_DATA);
    assign ctrl_sel      = (idx_q == IDX_CTRL);
    assign in_lock_range = ctrl_q.lock && (idx_q <= LOCK_LAST);

    // Index register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (idx_wr)
            idx_q <= io_wdata;
    end

    // Control register update; bit 6 is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.lock     <= 1'b0;
            ctrl_q.en_n     <= 1'b0;
            ctrl_q.clr_n    <= 1'b0;
            ctrl_q.sync_end <= '0;
        end else if (dat_wr && ctrl_sel) begin
            ctrl_q.lock     <= io_wdata[7];
            ctrl_q.en_n     <= io_wdata[5];
            ctrl_q.clr_n    <= io_wdata[4];
            ctrl_q.sync_end <= io_wdata[END_W-1:0];
        end
    end

    // Readback mux for the two ports.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (hit)
                HIT_INDEX: io_rdata = idx_q;
                HIT_DATA:  if (ctrl_sel)
                               io_rdata = {ctrl_q.lock, 1'b0, ctrl_q.en_n,
                                           ctrl_q.clr_n, ctrl_q.sync_end};
                default:   io_rdata = '0;
            endcase
        end
    end

    assign crt_wr_stb = dat_wr && !ctrl_sel;

    // Per-bit write permission; one bit of one register escapes the lock.
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        if (b == EXEMPT_BIT) begin : g_exempt
            assign crt_wr_mask[b] = !in_lock_range || (idx_q == EXEMPT_IDX);
        end else begin : g_plain
            assign crt_wr_mask[b] = !in_lock_range;
        end
    end
endmodule

// File: rtl/crt_vs_sync.sv
// Vertical sync generator: full-width start match, END_W-bit end match.
// Assumes line_cnt holds each value for at least one clock.
module crt_vs_sync #(
    parameter int LINE_W = 11,
    parameter int END_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [LINE_W-1:0] vs_start,
    input  logic [END_W-1:0]  sync_end,
    output logic              vsync,
    output logic              vs_rise
);
    logic start_hit;
    logic end_hit;
    logic vs_prev;

    assign start_hit = (line_cnt == vs_start);
    assign end_hit   = (line_cnt[END_W-1:0] == sync_end);

    // Sync level: start wins over end on the same line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vsync <= 1'b0;
        else if (start_hit)
            vsync <= 1'b1;
        else if (end_hit)
            vsync <= 1'b0;
    end

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vs_prev <= 1'b0;
        else
            vs_prev <= vsync;
    end

    assign vs_rise = vsync && !vs_prev;
endmodule

// File: rtl/crt_vs_irq.sv
// Retrace interrupt latch with active-low enable and level clear.
// Assumes vs_rise is a single-cycle pulse.
module crt_vs_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_rise,
    input  logic en_n,
    input  logic clr_n,
    output logic pending
);
    // Clear dominates; set only while armed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (!clr_n)
            pending <= 1'b0;
        else if (vs_rise && !en_n)
            pending <= 1'b1;
    end
endmodule

// File: rtl/crt_vsync_retrace.sv
// Top level: vertical sync, retrace interrupt flag and CRT register 11h
// with the write lock for registers 00h-07h. Assumes a single clock domain.
module crt_vsync_retrace
    import crt_vs_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              color_mode,
    input  logic [15:0]       io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [LINE_W-1:0] vs_start,
    output logic              vsync,
    output logic              retrace_irq_pend,
    output logic [7:0]        crt_index,
    output logic              crt_wr_stb,
    output logic [7:0]        crt_wr_mask,
    output logic              regs_locked
);
    port_hit_e        hit;
    ctrl_t            ctrl_q;
    logic             vs_rise;
    logic             ctrl_en_n;
    logic             ctrl_clr_n;
    logic             ctrl_prot;
    logic [END_W-1:0] ctrl_end;

    crt_vs_decode u_decode (
        .io_addr    (io_addr),
        .color_mode (color_mode),
        .hit        (hit)
    );

    crt_vs_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .idx_q       (crt_index),
        .ctrl_q      (ctrl_q),
        .crt_wr_stb  (crt_wr_stb),
        .crt_wr_mask (crt_wr_mask)
    );

    assign ctrl_en_n   = ctrl_q.en_n;
    assign ctrl_clr_n  = ctrl_q.clr_n;
    assign ctrl_prot   = ctrl_q.lock;
    assign ctrl_end    = ctrl_q.sync_end;
    assign regs_locked = ctrl_prot;

    crt_vs_sync #(.LINE_W(LINE_W), .END_W(END_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_cnt (line_cnt),
        .vs_start (vs_start),
        .sync_end (ctrl_end),
        .vsync    (vsync),
        .vs_rise  (vs_rise)
    );

    crt_vs_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .vs_rise (vs_rise),
        .en_n    (ctrl_en_n),
        .clr_n   (ctrl_clr_n),
        .pending (retrace_irq_pend)
    );
endmodule

// File: rtl/crt_vs_chk.sv
// Property checker for crt_vsync_retrace, attached by bind.
module crt_vs_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINE_W-1:0] line_cnt,
    input logic [LINE_W-1:0] vs_start,
    input logic              vsync,
    input logic              retrace_irq_pend,
    input logic              ctrl_en_n,
    input logic              ctrl_clr_n,
    input logic              ctrl_prot,
    input logic [3:0]        ctrl_end,
    input logic [7:0]        crt_index,
    input logic [7:0]        crt_wr_mask
);
    assert_vs_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt == vs_start) |=> vsync);

    assert_vs_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt != vs_start && line_cnt[3:0] == ctrl_end) |=> !vsync);

    assert_pend_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retrace_irq_pend) |-> ($past(vsync) && !$past(ctrl_en_n) && $past(ctrl_clr_n)));

    assert_no_set_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en_n && !retrace_irq_pend) |=> !retrace_irq_pend);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_clr_n |=> !retrace_irq_pend);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retrace_irq_pend && ctrl_clr_n) |=> retrace_irq_pend);

    assert_lock_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_prot && crt_index < 8'h07) |-> (crt_wr_mask == 8'h00));

    assert_exempt_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (crt_index == 8'h07) |-> crt_wr_mask[4]);
endmodule

bind crt_vsync_retrace crt_vs_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/crt_vsync_retrace_bench.sv
`timescale 1ns/1ps
module crt_vsync_retrace_bench;
    localparam int LW = 11;
    localparam int LMOD = 1 << LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          color_mode = 1'b1;
    logic [15:0]   io_addr = 16'h0;
    logic          io_wr = 1'b0;
    logic          io_rd = 1'b0;
    logic [7:0]    io_wdata = 8'h0;
    logic [7:0]    io_rdata;
    logic [LW-1:0] line_cnt = '0;
    logic [LW-1:0] vs_start = 11'd1500;
    logic          vsync;
    logic          retrace_irq_pend;
    logic [7:0]    crt_index;
    logic          crt_wr_stb;
    logic [7:0]    crt_wr_mask;
    logic          regs_locked;

    int checks = 0;
    int errors = 0;

    crt_vsync_retrace #(.LINE_W(LW)) u_crt_vsync_retrace (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference state.
    int  m_idx, m_end;
    bit  m_lock, m_en_n, m_clr_n, m_vs, m_vs_prev, m_pend, m_known, m_live;

    function automatic int hit_of(input logic [15:0] a, input logic cm);
        if (a == (cm ? 16'h3D4 : 16'h3B4)) return 1;
        if (a == (cm ? 16'h3D5 : 16'h3B5)) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        int h, exp_rd, exp_mask;
        bit n_vs, n_pend;
        if (!rst_n) begin
            m_idx = 0; m_lock = 0; m_en_n = 0; m_clr_n = 0; m_end = 0;
            m_vs = 0; m_vs_prev = 0; m_pend = 0; m_known = 0; m_live = 1;
        end else if (m_live) begin
            h = hit_of(io_addr, color_mode);
            chk("R4 R5 vsync", {7'd0, vsync}, {7'd0, m_vs});
            chk("R6 R7 R8 pending", {7'd0, retrace_irq_pend}, {7'd0, m_pend});
            chk("R9 index", crt_index, m_idx[7:0]);
            chk("R3 locked", {7'd0, regs_locked}, {7'd0, m_lock});
            if (m_lock && m_idx <= 7) exp_mask = (m_idx == 7) ? 8'h10 : 8'h00;
            else exp_mask = 8'hFF;
            chk("R3 mask", crt_wr_mask, exp_mask[7:0]);
            chk("R9 strobe", {7'd0, crt_wr_stb}, {7'd0, (io_wr && h == 2 && m_idx != 8'h11)});
            exp_rd = 0;
            if (io_rd && h == 1) exp_rd = m_idx;
            if (io_rd && h == 2 && m_idx == 8'h11)
                exp_rd = {m_lock, 1'b0, m_en_n, m_clr_n, m_end[3:0]};
            if (m_known) chk("R2 rdata", io_rdata, exp_rd[7:0]);
            else         chk("R1 R2 rdata", io_rdata & 8'hA0, exp_rd[7:0] & 8'hA0);
            // next state
            n_vs = m_vs;
            if (int'(line_cnt) == int'(vs_start)) n_vs = 1;
            else if (int'(line_cnt) % 16 == m_end) n_vs = 0;
            n_pend = m_pend;
            if (!m_clr_n) n_pend = 0;
            else if (m_vs && !m_vs_prev && !m_en_n) n_pend = 1;
            m_vs_prev = m_vs; m_vs = n_vs; m_pend = n_pend;
            if (io_wr && h == 1) m_idx = io_wdata;
            if (io_wr && h == 2 && m_idx == 8'h11) begin
                m_lock = io_wdata[7]; m_en_n = io_wdata[5]; m_clr_n = io_wdata[4];
                m_end = io_wdata[3:0]; m_known = 1;
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] msk, input logic [7:0] exp, input string req);
        io_addr = a; io_rd = 1'b1;
        #1;
        chk(req, io_rdata & msk, exp);
        @(negedge clk);
        io_rd = 1'b0; io_addr = 16'h0;
    endtask

    task automatic sweep(input int first, input int count);
        for (int i = 0; i < count; i++) begin
            line_cnt = LW'((first + i) % LMOD);
            @(negedge clk); @(negedge clk);
        end
    endtask

    task automatic ctrl(input logic [7:0] v);
        wr(16'h3D4, 8'h11);
        wr(16'h3D5, v);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 vsync", {7'd0, vsync}, 8'd0);
        chk("R1 pending", {7'd0, retrace_irq_pend}, 8'd0);
        rd(16'h3D4, 8'hFF, 8'h00, "R1 index");
        wr(16'h3D4, 8'h11);
        rd(16'h3D5, 8'hA0, 8'h00, "R1 ctrl bits 7 5");
        // R2: readback, bit 6 reads 0
        wr(16'h3D5, 8'h7C);
        rd(16'h3D5, 8'hFF, 8'h3C, "R2 bit6 zero");
        rd(16'h3D4, 8'hFF, 8'h11, "R9 index readback");
        // R2: mono ports ignored in colour mode
        wr(16'h3B5, 8'h80);
        rd(16'h3B5, 8'hFF, 8'h00, "R2 foreign read");
        rd(16'h3D5, 8'hFF, 8'h3C, "R2 foreign write ignored");
        // R2: mono mode
        color_mode = 1'b0;
        wr(16'h3B4, 8'h11);
        wr(16'h3B5, 8'h95);
        rd(16'h3B5, 8'hFF, 8'h95, "R2 mono readback");
        wr(16'h3D5, 8'h00);
        rd(16'h3B5, 8'hFF, 8'h95, "R2 colour ignored in mono");
        // R3: lock on (bit 7 = 1 from 95h)
        for (int i = 0; i < 10; i++) begin
            wr(16'h3B4, 8'(i));
            if (i < 7)       chk("R3 locked index", crt_wr_mask, 8'h00);
            else if (i == 7) chk("R3 exempt bit", crt_wr_mask, 8'h10);
            else             chk("R3 outside range", crt_wr_mask, 8'hFF);
        end
        wr(16'h3B4, 8'h11);
        wr(16'h3B5, 8'h15);
        wr(16'h3B4, 8'h03);
        chk("R3 unlocked", crt_wr_mask, 8'hFF);
        color_mode = 1'b1;
        // R4 R5 R6: enabled, armed, end = (100+3)&15 = 7
        vs_start = 11'd100;
        ctrl(8'h17);
        sweep(96, 16);
        chk("R6 latched", {7'd0, retrace_irq_pend}, 8'd1);
        // R8: persists across another retrace
        sweep(96, 16);
        chk("R8 persists", {7'd0, retrace_irq_pend}, 8'd1);
        // R8: clear
        ctrl(8'h07);
        @(negedge clk);
        chk("R8 cleared", {7'd0, retrace_irq_pend}, 8'd0);
        // R7: clear held low, retrace ignored
        sweep(96, 16);
        chk("R7 clear low blocks", {7'd0, retrace_irq_pend}, 8'd0);
        // R7: enable off
        ctrl(8'h37);
        sweep(96, 16);
        chk("R7 disabled", {7'd0, retrace_irq_pend}, 8'd0);
        // R5: 16-line pulse, end = 200 & 15 = 8
        vs_start = 11'd200;
        ctrl(8'h38);
        sweep(198, 10);
        chk("R5 still high", {7'd0, vsync}, 8'd1);
        sweep(208, 10);
        chk("R5 ended after 16", {7'd0, vsync}, 8'd0);
        // R4 R5 R6: wrap through zero, start 7FEh, end 3
        ctrl(8'h10);
        vs_start = 11'h7FE;
        ctrl(8'h13);
        sweep(16'h7FA, 12);
        chk("R6 wrap latched", {7'd0, retrace_irq_pend}, 8'd1);
        chk("R5 wrap ended", {7'd0, vsync}, 8'd0);
        // R9: strobe for other index
        wr(16'h3D4, 8'h05);
        io_addr = 16'h3D5; io_wdata = 8'h00; io_wr = 1'b1;
        #1 chk("R9 strobe other index", {7'd0, crt_wr_stb}, 8'd1);
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0;
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule